// File: doc/BRIEF.md
# Open-Page DRAM Command Scheduler

This block sits in front of one DDR3-style memory channel and turns a small pool of pending read and write requests into a stream of bank commands: ACTIVATE, PRECHARGE, READ and WRITE. Requests arrive with a direction, a bank, a row and a column, and are stored in a free slot of an eight-entry pool. The slot number is the request's tag for the rest of its life.

Each clock the scheduler inspects every pending entry at once against per-bank state (open flag, open row, and countdown timers for the activate-to-column delay and the precharge period). Column commands for entries whose row is already open are preferred over everything else, so a group of same-row requests drains back to back. When no such hit is ready, the oldest entry that can legally take its next ACTIVATE or PRECHARGE goes instead, which lets row preparation on one bank overlap the waiting time of another. A column command retires its entry and raises a one-cycle completion carrying the tag. The delays and a one-command-every-two-clocks launch mode are set by configuration inputs.

Top module: `rowhit_cmd_sched`

## Requirements
- R1: After reset every bank is closed, the pool is empty, `req_ready` is 1, `cmd_op` is 0 (NOP) with bank, row, column and slot fields 0, and `done_valid` is 0.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both 1, into the lowest-numbered empty slot; `req_ready` is 0 exactly when all eight slots are occupied. A slot freed by a retirement can be filled from the next clock on.
- R3: The command bus is registered: the decision made in one cycle appears on `cmd_op`, `cmd_bank`, `cmd_row`, `cmd_col` and `cmd_slot` after the next rising edge. Codes are 0 NOP, 1 ACTIVATE, 2 PRECHARGE, 3 READ, 4 WRITE; bank, row, column and slot fields carry the chosen entry's values.
- R4: An entry whose bank is open on its row and whose activate-to-column timer has expired is issued a READ or WRITE ahead of any entry that needs an ACTIVATE or PRECHARGE, so pending hits to one open row go out consecutively.
- R5: Among candidates of the same class (column hits, or row-preparation commands), the entry accepted earliest is chosen.
- R6: An ACTIVATE goes to a closed bank only once its precharge timer has expired; the first column command to that bank comes no sooner than `cfg_trcd` clocks after the ACTIVATE (a value of 0 behaves as 1).
- R7: A PRECHARGE goes to an open bank only for an entry whose row differs from the open row, only when no pending entry hits that open row and the activate-to-column timer has expired; the next ACTIVATE to that bank comes no sooner than `cfg_trp` clocks after it.
- R8: While one bank waits between its ACTIVATE and its column command, commands to other banks may be issued in between.
- R9: With `cfg_2n` at 1, every cycle following a non-NOP command carries a NOP; with `cfg_2n` at 0 a command may issue every clock.
- R10: A READ or WRITE retires its entry; `done_valid` pulses in the same cycle the column command is on the bus, with `done_tag` equal to `cmd_slot`.
- R11: When no entry is eligible, or the pool is empty, `cmd_op` is NOP and `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 10 | Target column |
| req_ready | output | 1 | A slot is free |
| cfg_trcd | input | 4 | Activate-to-column delay in clocks |
| cfg_trp | input | 4 | Precharge period in clocks |
| cfg_2n | input | 1 | 1 selects one command per two clocks |
| cmd_op | output | 3 | Command code (0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR) |
| cmd_bank | output | 3 | Command bank |
| cmd_row | output | 14 | Row of the served entry |
| cmd_col | output | 10 | Column of the served entry |
| cmd_slot | output | 3 | Slot the command serves |
| done_valid | output | 1 | Entry retired this cycle |
| done_tag | output | 3 | Slot of the retired entry |

## Verification
The hardest case to reach is a row conflict on a bank whose open row is still wanted: a PRECHARGE must be withheld while a newer hit to the open row waits out its activate-to-column timer, and only afterwards may the older conflicting entry proceed. The stimulus sends a hit, a conflict and a second hit to the same bank on consecutive clocks, so the second hit overtakes the conflict; it then packs the pool full with mixed banks and a few rows so that conflicts, hits and overlap across banks occur together under both launch modes and several timer settings.

// File: rtl/rowhit_cmd_sched.sv
module rowhit_cmd_sched #(
  parameter int QDEPTH = 8,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int TW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [$clog2(NBANK)-1:0]  req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic              cfg_2n,
  output logic [2:0]        cmd_op,
  output logic [$clog2(NBANK)-1:0]  cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [$clog2(QDEPTH)-1:0] cmd_slot,
  output logic              done_valid,
  output logic [$clog2(QDEPTH)-1:0] done_tag
);
  localparam int SLOT_W = $clog2(QDEPTH);
  localparam int BANK_W = $clog2(NBANK);
  localparam logic [2:0] OP_NOP = 3'd0, OP_ACT = 3'd1, OP_PRE = 3'd2,
                         OP_RD  = 3'd3, OP_WR  = 3'd4;

  logic [QDEPTH-1:0] q_vld, q_wr;
  logic [BANK_W-1:0] q_bank [QDEPTH];
  logic [ROW_W-1:0]  q_row  [QDEPTH];
  logic [COL_W-1:0]  q_col  [QDEPTH];
  logic [QDEPTH-1:0] older  [QDEPTH];

  logic [NBANK-1:0]  b_open;
  logic [ROW_W-1:0]  b_row   [NBANK];
  logic [TW-1:0]     rcd_cnt [NBANK];
  logic [TW-1:0]     rp_cnt  [NBANK];

  logic [QDEPTH-1:0] hit, col_ok, act_ok, pre_ok, pool, ret_mask;
  logic [NBANK-1:0]  hitbank;
  logic              gate, sel_any, is_col, accept;
  logic [SLOT_W-1:0] sel, alloc_idx;
  logic [2:0]        nxt_op;
  logic [TW-1:0]     trcd_m1, trp_m1;

  always_comb begin
    hit = '0;
    hitbank = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      hit[i] = q_vld[i] && b_open[q_bank[i]] && (b_row[q_bank[i]] == q_row[i]);
      if (hit[i]) hitbank[q_bank[i]] = 1'b1;
    end
    for (int i = 0; i < QDEPTH; i++) begin
      col_ok[i] = hit[i] && (rcd_cnt[q_bank[i]] == '0);
      act_ok[i] = q_vld[i] && !b_open[q_bank[i]] && (rp_cnt[q_bank[i]] == '0);
      pre_ok[i] = q_vld[i] && b_open[q_bank[i]] && !hit[i] &&
                  !hitbank[q_bank[i]] && (rcd_cnt[q_bank[i]] == '0);
    end
  end

  assign gate = !(cfg_2n && cmd_op != OP_NOP);
  assign pool = !gate ? '0 : ((|col_ok) ? col_ok : (act_ok | pre_ok));

  always_comb begin
    sel = '0;
    sel_any = 1'b0;
    for (int i = 0; i < QDEPTH; i++)
      if (pool[i] && !(|(pool & older[i]))) begin
        sel = SLOT_W'(i);
        sel_any = 1'b1;
      end
  end

  always_comb begin
    nxt_op = OP_NOP;
    if (sel_any) begin
      if (col_ok[sel])      nxt_op = q_wr[sel] ? OP_WR : OP_RD;
      else if (act_ok[sel]) nxt_op = OP_ACT;
      else                  nxt_op = OP_PRE;
    end
  end

  assign is_col   = sel_any && col_ok[sel];
  assign ret_mask = is_col ? (QDEPTH'(1) << sel) : '0;

  always_comb begin
    alloc_idx = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (!q_vld[i]) alloc_idx = SLOT_W'(i);
  end

  assign req_ready = ~&q_vld;
  assign accept    = req_valid && req_ready;
  assign trcd_m1   = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;
  assign trp_m1    = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld <= '0;
      q_wr  <= '0;
      b_open <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_bank[i] <= '0; q_row[i] <= '0; q_col[i] <= '0; older[i] <= '0;
      end
      for (int b = 0; b < NBANK; b++) begin
        b_row[b] <= '0; rcd_cnt[b] <= '0; rp_cnt[b] <= '0;
      end
      cmd_op <= OP_NOP; cmd_bank <= '0; cmd_row <= '0; cmd_col <= '0;
      cmd_slot <= '0; done_valid <= 1'b0; done_tag <= '0;
    end else begin
      cmd_op     <= nxt_op;
      cmd_bank   <= sel_any ? q_bank[sel] : '0;
      cmd_row    <= sel_any ? q_row[sel]  : '0;
      cmd_col    <= sel_any ? q_col[sel]  : '0;
      cmd_slot   <= sel;
      done_valid <= is_col;
      done_tag   <= sel;

      for (int b = 0; b < NBANK; b++) begin
        if (rcd_cnt[b] != '0) rcd_cnt[b] <= rcd_cnt[b] - 1'b1;
        if (rp_cnt[b]  != '0) rp_cnt[b]  <= rp_cnt[b]  - 1'b1;
        if (sel_any && q_bank[sel] == BANK_W'(b)) begin
          if (nxt_op == OP_ACT) begin
            b_open[b]  <= 1'b1;
            b_row[b]   <= q_row[sel];
            rcd_cnt[b] <= trcd_m1;
          end else if (nxt_op == OP_PRE) begin
            b_open[b]  <= 1'b0;
            rp_cnt[b]  <= trp_m1;
          end
        end
      end

      q_vld <= (q_vld & ~ret_mask) | (accept ? (QDEPTH'(1) << alloc_idx) : '0);
      if (accept) begin
        q_wr[alloc_idx]   <= req_write;
        q_bank[alloc_idx] <= req_bank;
        q_row[alloc_idx]  <= req_row;
        q_col[alloc_idx]  <= req_col;
        for (int i = 0; i < QDEPTH; i++) older[i][alloc_idx] <= 1'b0;
        older[alloc_idx] <= q_vld & ~ret_mask;
      end
    end
  end
endmodule

// File: rtl/rowhit_cmd_sched_chk.sv
module rowhit_cmd_sched_chk #(
  parameter int QDEPTH = 8,
  parameter int NBANK  = 8,
  parameter int TW     = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [TW-1:0]             cfg_trcd,
  input logic [TW-1:0]             cfg_trp,
  input logic                      cfg_2n,
  input logic [2:0]                cmd_op,
  input logic [$clog2(NBANK)-1:0]  cmd_bank,
  input logic [$clog2(QDEPTH)-1:0] cmd_slot,
  input logic                      done_valid,
  input logic [$clog2(QDEPTH)-1:0] done_tag
);
  localparam int CW = TW + 4;
  localparam int OW = $clog2(QDEPTH) + 2;

  logic [CW-1:0] since_act [NBANK];
  logic [CW-1:0] since_pre [NBANK];
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      for (int b = 0; b < NBANK; b++) begin
        since_act[b] <= '1; since_pre[b] <= '1;
      end
    end else begin
      occ <= occ + OW'(req_valid && req_ready) - OW'(done_valid);
      for (int b = 0; b < NBANK; b++) begin
        if (cmd_op == 3'd1 && cmd_bank == b[$clog2(NBANK)-1:0]) since_act[b] <= CW'(1);
        else if (since_act[b] != '1) since_act[b] <= since_act[b] + 1'b1;
        if (cmd_op == 3'd2 && cmd_bank == b[$clog2(NBANK)-1:0]) since_pre[b] <= CW'(1);
        else if (since_pre[b] != '1) since_pre[b] <= since_pre[b] + 1'b1;
      end
    end
  end

  AST_READY_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == ((occ - OW'(done_valid)) < OW'(QDEPTH))); // R2

  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd3 || cmd_op == 3'd4) |-> since_act[cmd_bank] >= CW'(cfg_trcd)); // R6

  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1) |-> since_pre[cmd_bank] >= CW'(cfg_trp)); // R7

  AST_TWO_CLOCK_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_2n && cmd_op != 3'd0) |=> (cmd_op == 3'd0)); // R9

  AST_DONE_ON_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ((cmd_op == 3'd3 || cmd_op == 3'd4) && done_tag == cmd_slot)); // R10

  AST_NOP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd0) |-> !done_valid); // R11
endmodule

bind rowhit_cmd_sched rowhit_cmd_sched_chk #(.QDEPTH(QDEPTH), .NBANK(NBANK), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_2n(cfg_2n), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_slot(cmd_slot), .done_valid(done_valid), .done_tag(done_tag)
);

// File: tb/rowhit_cmd_sched_tb.sv
module rowhit_cmd_sched_tb_top;
  localparam int QD = 8, NB = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_bank = 0;
  logic [13:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic [3:0] cfg_trcd = 6, cfg_trp = 6;
  logic cfg_2n = 0;
  logic req_ready, done_valid;
  logic [2:0] cmd_op, cmd_bank, cmd_slot, done_tag;
  logic [13:0] cmd_row;
  logic [9:0] cmd_col;

  always #4 clk = ~clk;

  rowhit_cmd_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_2n(cfg_2n), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_slot(cmd_slot),
    .done_valid(done_valid), .done_tag(done_tag));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  int m_vld[QD], m_wr[QD], m_bank[QD], m_row[QD], m_col[QD], m_seq[QD];
  int m_open[NB], m_orow[NB], m_rcd[NB], m_rp[NB];
  int seqc = 0;
  int e_op = 0, e_bank = 0, e_row = 0, e_col = 0, e_slot = 0, e_done = 0, e_tag = 0;

  int act_at[NB], pre_at[NB], act_pend[NB];
  int prev_op = 0, overlap_seen = 0, full_seen = 0;
  int tags[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int ready_e = 0;
    cyc++;
    for (int i = 0; i < QD; i++) if (!m_vld[i]) ready_e = 1;
    chk(int'(cmd_op) == e_op, "R5 op", int'(cmd_op), e_op);
    chk(int'(cmd_slot) == e_slot, "R5 slot", int'(cmd_slot), e_slot);
    chk(int'(cmd_bank) == e_bank && int'(cmd_row) == e_row && int'(cmd_col) == e_col,
        "R3 fields", int'(cmd_row), e_row);
    chk(int'(done_valid) == e_done && (!e_done || int'(done_tag) == e_tag),
        "R10 done", int'(done_tag), e_tag);
    chk(int'(req_ready) == ready_e, "R2 ready", int'(req_ready), ready_e);
    if (!req_ready) full_seen = 1;
    if (done_valid) tags.push_back(int'(done_tag));
    if (cmd_op != 0) begin
      for (int b = 0; b < NB; b++)
        if (act_pend[b] && b != int'(cmd_bank)) overlap_seen = 1;
    end
    if (cmd_op == 1) begin
      chk(cyc - pre_at[cmd_bank] >= int'(cfg_trp), "R7 pre-to-act", cyc - pre_at[cmd_bank], int'(cfg_trp));
      act_at[cmd_bank] = cyc; act_pend[cmd_bank] = 1;
    end
    if (cmd_op == 2) pre_at[cmd_bank] = cyc;
    if (cmd_op == 3 || cmd_op == 4) begin
      chk(cyc - act_at[cmd_bank] >= int'(cfg_trcd), "R6 act-to-col", cyc - act_at[cmd_bank], int'(cfg_trcd));
      act_pend[cmd_bank] = 0;
    end
    if (cfg_2n && prev_op != 0) chk(cmd_op == 0, "R9 2n gap", int'(cmd_op), 0);
    prev_op = int'(cmd_op);
  endtask

  function automatic int bank_hit(input int bk);
    for (int j = 0; j < QD; j++)
      if (m_vld[j] && m_bank[j] == bk && m_open[bk] && m_orow[bk] == m_row[j]) return 1;
    return 0;
  endfunction

  task automatic model(input bit v, input bit w, input int b, input int r, input int c);
    int pick = -1, ppri = 9, pcls = 9, free_slot = -1;
    bit gate = !(cfg_2n && e_op != 0);
    for (int i = 0; i < QD; i++) begin
      if (m_vld[i] && gate) begin
        int bk = m_bank[i];
        int cls = 9;
        int hit = m_open[bk] && m_orow[bk] == m_row[i];
        if (hit && m_rcd[bk] == 0) cls = 0;
        else if (!m_open[bk] && m_rp[bk] == 0) cls = 1;
        else if (m_open[bk] && !hit && !bank_hit(bk) && m_rcd[bk] == 0) cls = 2;
        if (cls != 9) begin
          int pri = (cls == 0) ? 0 : 1;
          if (pick < 0 || pri < ppri || (pri == ppri && m_seq[i] < m_seq[pick])) begin
            pick = i; ppri = pri; pcls = cls;
          end
        end
      end
    end
    for (int i = QD - 1; i >= 0; i--) if (!m_vld[i]) free_slot = i;
    for (int k = 0; k < NB; k++) begin
      if (m_rcd[k] > 0) m_rcd[k]--;
      if (m_rp[k] > 0) m_rp[k]--;
    end
    e_op = 0; e_bank = 0; e_row = 0; e_col = 0; e_slot = 0; e_done = 0;
    if (pick >= 0) begin
      int bk = m_bank[pick];
      e_bank = bk; e_row = m_row[pick]; e_col = m_col[pick]; e_slot = pick;
      if (pcls == 0) begin
        e_op = m_wr[pick] ? 4 : 3; e_done = 1; e_tag = pick; m_vld[pick] = 0;
      end else if (pcls == 1) begin
        e_op = 1; m_open[bk] = 1; m_orow[bk] = m_row[pick];
        m_rcd[bk] = (cfg_trcd > 0) ? int'(cfg_trcd) - 1 : 0;
      end else begin
        e_op = 2; m_open[bk] = 0;
        m_rp[bk] = (cfg_trp > 0) ? int'(cfg_trp) - 1 : 0;
      end
    end
    if (v && free_slot >= 0) begin
      m_vld[free_slot] = 1; m_wr[free_slot] = w; m_bank[free_slot] = b;
      m_row[free_slot] = r; m_col[free_slot] = c; m_seq[free_slot] = seqc++;
    end
  endtask

  task automatic step(input bit v, input bit w, input int b, input int r, input int c);
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_bank = 3'(b); req_row = 14'(r); req_col = 10'(c);
    model(v, w, b, r, c);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic traffic(input int n, input int nbanks);
    for (int k = 0; k < n; k++) begin
      bit v = ($urandom % 3) != 0;
      step(v, 1'($urandom), int'($urandom % nbanks), int'($urandom % 3), int'($urandom % 1024));
    end
  endtask

  initial begin
    for (int i = 0; i < QD; i++) m_vld[i] = 0;
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_orow[b] = 0; m_rcd[b] = 0; m_rp[b] = 0;
      act_at[b] = -1000; pre_at[b] = -1000; act_pend[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: state straight after reset
    chk(cmd_op == 0 && done_valid == 0 && req_ready == 1 && cmd_slot == 0 && cmd_row == 0,
        "R1 reset", int'(cmd_op), 0);

    // R4: hit, conflict, second hit to bank 0 -> tags 0,2,1
    step(1, 0, 0, 5, 10);
    step(1, 1, 0, 9, 20);
    step(1, 0, 0, 5, 30);
    idle(60);
    chk(tags.size() == 3, "R4 count", tags.size(), 3);
    if (tags.size() == 3)
      chk(tags[0] == 0 && tags[1] == 2 && tags[2] == 1, "R4 order", tags[1], 2);

    // R8: two closed banks, second ACT slips in before first column
    step(1, 0, 1, 1, 1);
    step(1, 0, 2, 2, 2);
    idle(40);
    chk(overlap_seen == 1, "R8 overlap", overlap_seen, 1);

    // R2: push more than fits in one burst
    for (int k = 0; k < 11; k++) step(1, k[0], k % 2, k % 3, k);
    idle(300);
    chk(full_seen == 1, "R2 full seen", full_seen, 1);

    // R11: drained pool leaves the bus idle
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 0, 0, 0);
      chk(cmd_op == 0 && done_valid == 0, "R11 idle", int'(cmd_op), 0);
    end

    cfg_trcd = 2; cfg_trp = 3;
    traffic(500, 4);
    idle(300);

    cfg_trcd = 7; cfg_trp = 7; cfg_2n = 1;
    traffic(500, 8);
    idle(400);

    cfg_trcd = 0; cfg_trp = 1; cfg_2n = 0;
    traffic(300, 2);
    idle(200);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule